// File: doc/BRIEF.md
# Parameterized Array Multiplier with Optional Two's-Complement Mode

This block multiplies two N-bit operands and returns the full 2N-bit product with no clock and no state. A grid of two-input gates forms the partial products. A stack of N-1 adder rows reduces them, and each row ripples its carries from the low end to the high end. The row below adds each row's shifted sum to the next partial-product row.

The `SIGNED` parameter selects the number format. When it is 0, both operands and the product are unsigned. When it is 1, all three are two's-complement. Signed mode does not widen the operands with sign extension. Instead it inverts the partial products that pair one operand's sign bit with a non-sign bit of the other, adds one constant one into the first row, and flips the top product bit. The array keeps the same shape in both modes.

Top module: `bw_array_mult`

## Requirements
- R1: With SIGNED=0, p_o equals the unsigned product of a_i and b_i over all 2N bits.
- R2: With SIGNED=1, p_o equals the two's-complement product of a_i and b_i, read as a signed 2N-bit value. When both operands are nonzero, bit 2N-1 of p_o is the XOR of the two operand sign bits.
- R3: Bit 0 of p_o is a_i[0] AND b_i[0] in both modes.
- R4: If either operand is zero, p_o is zero in both modes.
- R5: A unit operand (value 1) gives the other operand at the output: zero-extended to 2N bits when SIGNED=0, sign-extended when SIGNED=1.
- R6: With SIGNED=1, the most negative value times itself gives +2^(2N-2), for example 0x40 for N=4. The most negative value times the most positive value gives the correct negative result, for example 0xC8 (-56) for N=4.
- R7: With SIGNED=0, all-ones times all-ones gives (2^N-1)^2, for example 0xE1 for N=4 and 0xFE01 for N=8.
- R8: The block holds no state. p_o follows a change of a_i or b_i within the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Multiplicand |
| b_i | input | N | Multiplier |
| p_o | output | 2N | Full-width product |

## Verification
The hardest case to reach is a carry that travels the full length of several rows and reaches the top cell. In signed mode this carry must meet both the injected constant and the inverted sign terms. Random operands seldom do this, because the effect needs sign bits set together with long runs of ones. The bench therefore checks every operand pair at N=4 in both modes. At N=8 it adds directed extremes to seeded random vectors: the most negative value, all-ones, the unit value and alternating bit patterns.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    typedef enum logic {
        CELL_HALF = 1'b0,
        CELL_FULL = 1'b1
    } cell_kind_e;

    // A partial product is inverted in two's-complement mode when exactly
    // one of its two operand bits is a sign bit.
    function automatic bit pp_inverted(input int row, input int col,
                                       input int width, input bit sgn);
        return sgn && ((row == width - 1) != (col == width - 1));
    endfunction

endpackage

// File: rtl/bwm_add_cell.sv
module bwm_add_cell #(
    parameter bwm_pkg::cell_kind_e KIND = bwm_pkg::CELL_FULL
) (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    generate
        if (KIND == bwm_pkg::CELL_FULL) begin : g_full
            assign s_o = x_i ^ y_i ^ c_i;
            assign c_o = (x_i & y_i) | (c_i & (x_i ^ y_i));
        end else begin : g_half
            assign s_o = x_i ^ y_i;
            assign c_o = x_i & y_i;
        end
    endgenerate

    // The cell's two outputs count the ones on its used inputs.
    always_comb begin
        if (!$isunknown({x_i, y_i, c_i})) begin
            p_cell_count_r1: assert ({c_o, s_o} == (2'(x_i) + 2'(y_i)
                + ((KIND == bwm_pkg::CELL_FULL) ? 2'(c_i) : 2'd0)));
        end
    end
endmodule

// File: rtl/bwm_pp_grid.sv
module bwm_pp_grid #(
    parameter int N      = 8,
    parameter bit SIGNED = 1'b1
) (
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [N*N-1:0] pp_o
);
    // pp_o[j*N + i] carries the product term of a_i[i] and b_i[j].
    for (genvar j = 0; j < N; j++) begin : g_row
        for (genvar i = 0; i < N; i++) begin : g_col
            localparam bit INV = bwm_pkg::pp_inverted(j, i, N, SIGNED);
            if (INV) begin : g_nand
                assign pp_o[j*N + i] = ~(a_i[i] & b_i[j]);
            end else begin : g_and
                assign pp_o[j*N + i] = a_i[i] & b_i[j];
            end
        end
    end
endmodule

// File: rtl/bwm_add_row.sv
module bwm_add_row #(
    parameter int N        = 8,
    parameter bit TOP_HALF = 1'b0
) (
    input  logic [N-1:0] pp_i,
    input  logic [N-1:0] add_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);
    logic [N:0] carry;

    assign carry[0] = 1'b0;
    assign cout_o   = carry[N];

    for (genvar k = 0; k < N; k++) begin : g_cell
        if (k == 0) begin : g_low
            bwm_add_cell #(.KIND(bwm_pkg::CELL_HALF)) u_cell (
                .x_i(pp_i[k]), .y_i(add_i[k]), .c_i(carry[k]),
                .s_o(sum_o[k]), .c_o(carry[k+1]));
        end else if (k == N - 1 && TOP_HALF) begin : g_top_half
            bwm_add_cell #(.KIND(bwm_pkg::CELL_HALF)) u_cell (
                .x_i(pp_i[k]), .y_i(carry[k]), .c_i(add_i[k]),
                .s_o(sum_o[k]), .c_o(carry[k+1]));
        end else begin : g_mid
            bwm_add_cell #(.KIND(bwm_pkg::CELL_FULL)) u_cell (
                .x_i(pp_i[k]), .y_i(add_i[k]), .c_i(carry[k]),
                .s_o(sum_o[k]), .c_o(carry[k+1]));
        end
    end

    // A row adds its two operands exactly. The top half cell is used only
    // when that addend bit is tied to zero.
    always_comb begin
        if (!$isunknown({pp_i, add_i})) begin
            p_row_sum_r1: assert ({cout_o, sum_o} ==
                ((N+1)'(pp_i) + (N+1)'(add_i)));
        end
    end
endmodule

// File: rtl/bw_array_mult.sv
module bw_array_mult #(
    parameter int N      = 8,
    parameter bit SIGNED = 1'b1
) (
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [2*N-1:0] p_o
);
    localparam int ROWS = N - 1;

    logic [N*N-1:0] pp;
    logic [N-1:0]   row_add [ROWS];
    logic [N-1:0]   row_sum [ROWS];
    logic [ROWS-1:0] row_cout;

    bwm_pp_grid #(.N(N), .SIGNED(SIGNED)) u_grid (
        .a_i(a_i), .b_i(b_i), .pp_o(pp));

    assign p_o[0] = pp[0];

    for (genvar r = 1; r <= ROWS; r++) begin : g_red
        if (r == 1) begin : g_first
            // The constant one in signed mode sits at weight 2^N.
            assign row_add[r-1] = {1'(SIGNED), pp[N-1:1]};
        end else begin : g_next
            assign row_add[r-1] = {row_cout[r-2], row_sum[r-2][N-1:1]};
        end

        bwm_add_row #(.N(N), .TOP_HALF((r == 1) && !SIGNED)) u_row (
            .pp_i(pp[r*N +: N]), .add_i(row_add[r-1]),
            .sum_o(row_sum[r-1]), .cout_o(row_cout[r-1]));

        if (r < ROWS) begin : g_low_bit
            assign p_o[r] = row_sum[r-1][0];
        end
    end

    assign p_o[2*N-2:N-1] = row_sum[ROWS-1];
    assign p_o[2*N-1]     = row_cout[ROWS-1] ^ SIGNED;

    function automatic logic [2*N-1:0] widen(input logic [N-1:0] v);
        return SIGNED ? {{N{v[N-1]}}, v} : {{N{1'b0}}, v};
    endfunction

    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            if (a_i == '0 || b_i == '0) begin
                p_zero_r4: assert (p_o == '0);
            end
            if (a_i == N'(1)) begin
                p_unit_a_r5: assert (p_o == widen(b_i));
            end
            if (b_i == N'(1)) begin
                p_unit_b_r5: assert (p_o == widen(a_i));
            end
            if (SIGNED && a_i != '0 && b_i != '0) begin
                p_sign_r2: assert (p_o[2*N-1] == (a_i[N-1] ^ b_i[N-1]));
            end
        end
    end
endmodule

// File: tb/bw_array_mult_test.sv
module bw_array_mult_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    logic [7:0]  a8, b8;
    logic [3:0]  a4, b4;
    logic [15:0] ps8, pu8;
    logic [7:0]  ps4, pu4;

    bw_array_mult #(.N(8), .SIGNED(1'b1)) uut    (.a_i(a8), .b_i(b8), .p_o(ps8));
    bw_array_mult #(.N(8), .SIGNED(1'b0)) uut_u8 (.a_i(a8), .b_i(b8), .p_o(pu8));
    bw_array_mult #(.N(4), .SIGNED(1'b1)) uut_s4 (.a_i(a4), .b_i(b4), .p_o(ps4));
    bw_array_mult #(.N(4), .SIGNED(1'b0)) uut_u4 (.a_i(a4), .b_i(b4), .p_o(pu4));

    function automatic logic [15:0] ref8(input logic [7:0] a, input logic [7:0] b,
                                         input bit sgn);
        logic signed [15:0] ea, eb;
        ea = sgn ? {{8{a[7]}}, a} : {8'h00, a};
        eb = sgn ? {{8{b[7]}}, b} : {8'h00, b};
        return ea * eb;
    endfunction

    function automatic logic [7:0] ref4(input logic [3:0] a, input logic [3:0] b,
                                        input bit sgn);
        logic signed [7:0] ea, eb;
        ea = sgn ? {{4{a[3]}}, a} : {4'h0, a};
        eb = sgn ? {{4{b[3]}}, b} : {4'h0, b};
        return ea * eb;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive8(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        a8 = a;
        b8 = b;
        #1;
    endtask

    task automatic drive4(input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        a4 = a;
        b4 = b;
        #1;
    endtask

    task automatic check8(input string tag);
        check({tag, " signed"},   ps8, ref8(a8, b8, 1'b1));
        check({tag, " unsigned"}, pu8, ref8(a8, b8, 1'b0));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_b00c));
        a8 = '0; b8 = '0; a4 = '0; b4 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R4: zero operands at start
        @(negedge clk); #1;
        check("R4 zero start s8", ps8, 16'h0000);
        check("R4 zero start u8", pu8, 16'h0000);
        check("R4 zero start s4", {8'h00, ps4}, 16'h0000);
        check("R4 zero start u4", {8'h00, pu4}, 16'h0000);

        // R1 R2: every 4-bit pair in both modes
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                drive4(4'(i), 4'(j));
                check("R1 exhaustive u4", {8'h00, pu4}, {8'h00, ref4(a4, b4, 1'b0)});
                check("R2 exhaustive s4", {8'h00, ps4}, {8'h00, ref4(a4, b4, 1'b1)});
                check("R3 lsb u4", {15'h0, pu4[0]}, {15'h0, a4[0] & b4[0]});
            end
        end

        // R6 and R7 corners at N=4
        drive4(4'h8, 4'h8);
        check("R6 min*min s4", {8'h00, ps4}, 16'h0040);
        drive4(4'h8, 4'h7);
        check("R6 min*max s4", {8'h00, ps4}, 16'h00C8);
        drive4(4'hF, 4'hF);
        check("R7 ones*ones u4", {8'h00, pu4}, 16'h00E1);

        // R4 R5 R6 R7 corners at N=8
        drive8(8'h00, 8'hA5); check8("R4 zero a");
        drive8(8'h5A, 8'h00); check8("R4 zero b");
        drive8(8'h01, 8'h93);
        check("R5 unit s8", ps8, 16'hFF93);
        check("R5 unit u8", pu8, 16'h0093);
        drive8(8'hC4, 8'h01);
        check("R5 unit b s8", ps8, 16'hFFC4);
        drive8(8'h80, 8'h80);
        check("R6 min*min s8", ps8, 16'h4000);
        drive8(8'h80, 8'h7F);
        check("R6 min*max s8", ps8, 16'hC080);
        drive8(8'hFF, 8'hFF);
        check("R7 ones*ones u8", pu8, 16'hFE01);
        check("R2 -1*-1 s8", ps8, 16'h0001);
        drive8(8'hAA, 8'h55); check8("R1 R2 alternating");
        drive8(8'h7F, 8'h7F); check8("R1 R2 max*max");

        // R8: a change seen within the same clock phase
        @(negedge clk);
        a8 = 8'h0C; b8 = 8'h0D; #1;
        check("R8 first value", pu8, 16'h009C);
        a8 = 8'h0E; #1;
        check("R8 no edge update", pu8, 16'h00B6);

        // R1 R2 R3: seeded random at N=8
        for (int k = 0; k < 3000; k++) begin
            drive8(8'($urandom), 8'($urandom));
            check8("R1 R2 random");
            check("R3 lsb s8", {15'h0, ps8[0]}, {15'h0, a8[0] & b8[0]});
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule